// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of read, write and execute grants. When a request is accepted, a combinational front end settles three kinds of request without touching memory. A physical-bypass request passes straight through. An address that is not properly sign-extended is refused. A kernel superpage maps directly onto physical memory.

Every other request starts a walk of three levels. Each level issues one 8-byte read over a simple request/response port. Each table entry supplies the base of the next level. The last entry supplies the page frame, per-mode read and write enables, and fault-on-operation bits.

The walker handles one walk at a time. It ignores new requests while busy. It reports the result in a single-cycle `done` pulse that carries the physical address, the permissions and a 3-bit fault code.

Top module: `pt_walker`

## Requirements
- R1: A request with `req_phys` high completes in the cycle after acceptance with `done_paddr` equal to `req_vaddr`, `done_prot` = 3'b111 and fault code 0, and raises no memory request. Permission bits are bit0 read, bit1 write, bit2 execute, and `req_need` uses the same bits.
- R2: When `req_phys` is low and bits [63:43] of the address are not all equal to bit 63, the result is access violation (code 1) with no memory request. A properly sign-extended negative address that is not a superpage is walked normally.
- R3: A negative canonical address with bits [42:41] = 2'b10 in mode 0 completes with no memory request. It gives physical bits [39:0] from the address, address bit 40 moved to physical bit 43, all other bits zero, and `done_prot` = 3'b111.
- R4: A superpage address in any mode other than 0 gives access violation (code 1).
- R5: The walk reads `ptbr + 8*va[42:33]`, then `B1 + 8*va[32:23]`, then `B2 + 8*va[22:13]`, where each base B is entry bits [63:32] shifted left by 13.
- R6: An entry with bit 0 (valid) clear at any level ends the walk with not-valid (code 2), and no further reads are made.
- R7: At levels 1 and 2, an entry whose bit 8 (mode-0 read enable) is clear ends the walk with access violation (code 1).
- R8: At level 3, entry bit 8+mode grants read and execute, and bit 12+mode grants write. A nonzero `req_need` with no overlap with these grants is access violation (code 1).
- R9: The grants are then masked by fault-on bits: entry bit 1 masks read, bit 2 masks write and bit 3 masks execute. If no needed access survives, the fault is fault-on-execute (5) if execute was needed, else fault-on-write (4) if write was needed, else fault-on-read (3).
- R10: On success (code 0), `done_paddr` is the level-3 frame OR'd with va[12:0], and `done_prot` is the masked grants. A `req_need` of zero always succeeds at a valid level-3 entry.
- R11: After reset `busy`, `done` and `mem_req_valid` are low. On any fault `done_paddr` and `done_prot` are zero. `done` lasts one cycle. `req_valid` while `busy` is high is ignored.
- R12: `mem_req_addr` is 8-byte aligned and holds steady while `mem_req_valid` is high and no response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_need | input | 3 | Required access: bit0 read, bit1 write, bit2 execute |
| req_mode | input | 2 | Privilege mode index, 0 = kernel |
| req_phys | input | 1 | Physical bypass |
| ptbr | input | 64 | Level-1 table base address |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| busy | output | 1 | Walker is not idle |
| done | output | 1 | One-cycle result pulse |
| done_paddr | output | 64 | Physical address |
| done_prot | output | 3 | Granted permissions |
| done_fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute |

## Verification
The cycle-level checks run on every cycle. They cover:
- the single-cycle `done` pulse;
- entry to `busy` on acceptance;
- the absence of memory traffic and the pass-through result during a bypass request;
- zeroed address and permissions on every fault;
- an aligned entry address that stays steady until the response arrives.

Only the bench scenarios can show that the right table entries are read and that each fault code comes from the right level and bit. They also cover the superpage bit relocation, the per-mode enable selection, the ordering of the fault-on priorities and the discarding of requests made during a walk.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker: fault codes and entry/access bit positions.
package ptw_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ACCESS   = 3'd1,
        FLT_NOTVALID = 3'd2,
        FLT_ON_READ  = 3'd3,
        FLT_ON_WRITE = 3'd4,
        FLT_ON_EXEC  = 3'd5
    } fault_e;

    localparam int unsigned ACC_R = 0;
    localparam int unsigned ACC_W = 1;
    localparam int unsigned ACC_X = 2;

    localparam int unsigned PTE_VALID  = 0;
    localparam int unsigned PTE_FO_LSB = 1;
    localparam int unsigned PTE_RD_LSB = 8;
    localparam int unsigned PTE_WR_LSB = 12;

endpackage

// File: rtl/ptw_precheck.sv
// Front-end resolver for the walker. It settles bypass, non-canonical and
// superpage requests combinationally, so they need no table reads.
// Assumes the superpage field and relocation positions sit below IMPL_VA_BITS.
module ptw_precheck
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W         = 64,
    parameter int unsigned IMPL_VA_BITS = 43,
    parameter int unsigned MODE_W       = 2
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [MODE_W-1:0] mode,
    input  logic              bypass,
    output logic              resolved,
    output fault_e            fault,
    output logic [VA_W-1:0]   paddr,
    output logic [2:0]        prot
);
    localparam int unsigned SP_SEL_LSB = IMPL_VA_BITS - 2;
    localparam int unsigned SP_KEEP    = IMPL_VA_BITS - 3;
    localparam int unsigned SP_DEST    = IMPL_VA_BITS;

    logic canonical;
    logic superpage;

    // Upper bits must all copy the sign bit.
    assign canonical = (&vaddr[VA_W-1:IMPL_VA_BITS]) | ~(|vaddr[VA_W-1:IMPL_VA_BITS]);
    // Negative address with selector field 2'b10.
    assign superpage = vaddr[VA_W-1] && (vaddr[SP_SEL_LSB +: 2] == 2'b10);

    // Resolve the request or hand it to the table walk.
    always_comb begin
        resolved = 1'b0;
        fault    = FLT_NONE;
        paddr    = '0;
        prot     = 3'b000;
        if (bypass) begin
            resolved = 1'b1;
            paddr    = vaddr;
            prot     = 3'b111;
        end else if (!canonical) begin
            resolved = 1'b1;
            fault    = FLT_ACCESS;
        end else if (superpage) begin
            resolved = 1'b1;
            if (mode != '0) begin
                fault = FLT_ACCESS;
            end else begin
                paddr[SP_KEEP-1:0] = vaddr[SP_KEEP-1:0];
                paddr[SP_DEST]     = vaddr[SP_KEEP];
                prot               = 3'b111;
            end
        end
    end

endmodule

// File: rtl/ptw_index_gen.sv
// Forms the table entry address for the current level: base + 8 * index.
// The level-0 index is the most significant field of the virtual page number.
module ptw_index_gen #(
    parameter int unsigned PA_W     = 64,
    parameter int unsigned IDX_BITS = 10,
    parameter int unsigned LEVELS   = 3,
    parameter int unsigned LVL_W    = 2
) (
    input  logic [LEVELS*IDX_BITS-1:0] vpn,
    input  logic [LVL_W-1:0]           level,
    input  logic [PA_W-1:0]            base,
    output logic [PA_W-1:0]            addr
);
    localparam int unsigned ENTRY_LG = 3;

    logic [IDX_BITS-1:0] idx_by_lvl [LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_field
            assign idx_by_lvl[g] = vpn[(LEVELS-1-g)*IDX_BITS +: IDX_BITS];
        end
    endgenerate

    // Pick the index field belonging to the active level.
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx_sel = idx_by_lvl[i];
        end
    end

    assign addr = base + {{(PA_W-IDX_BITS-ENTRY_LG){1'b0}}, idx_sel, {ENTRY_LG{1'b0}}};

endmodule

// File: rtl/ptw_leaf_perm.sv
// Evaluates a last-level entry. It picks the mode's read and write enables,
// checks them against the needed access, then applies the fault-on mask.
module ptw_leaf_perm
    import ptw_pkg::*;
#(
    parameter int unsigned MODE_W = 2,
    localparam int unsigned NMODE = 1 << MODE_W
) (
    input  logic              valid,
    input  logic [2:0]        fo_bits,
    input  logic [NMODE-1:0]  rd_en,
    input  logic [NMODE-1:0]  wr_en,
    input  logic [MODE_W-1:0] mode,
    input  logic [2:0]        need,
    output fault_e            fault,
    output logic [2:0]        prot
);
    logic [2:0] granted;
    logic [2:0] masked;

    // Read enable also grants execute.
    assign granted = {rd_en[mode], wr_en[mode], rd_en[mode]};
    assign masked  = granted & ~fo_bits;

    // Classify the outcome; the fault-on priority is execute, write, read.
    always_comb begin
        fault = FLT_NONE;
        prot  = 3'b000;
        if (!valid) begin
            fault = FLT_NOTVALID;
        end else if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
            fault = FLT_ACCESS;
        end else if ((need != 3'b000) && ((masked & need) == 3'b000)) begin
            if (need[ACC_X])      fault = FLT_ON_EXEC;
            else if (need[ACC_W]) fault = FLT_ON_WRITE;
            else                  fault = FLT_ON_READ;
        end else begin
            prot = masked;
        end
    end

endmodule

// File: rtl/pt_walker.sv
// Three-level page table walker. It runs one translation at a time.
// Requests that the front end resolves finish one cycle after acceptance.
// Others issue one entry read per level and finish one cycle after the last
// response. Assumes memory holds no more than one response per request.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W         = 64,
    parameter int unsigned PAGE_BITS    = 13,
    parameter int unsigned IDX_BITS     = 10,
    parameter int unsigned LEVELS       = 3,
    parameter int unsigned MODE_W       = 2,
    parameter int unsigned PFN_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [2:0]        req_need,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_phys,
    input  logic [VA_W-1:0]   ptbr,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              busy,
    output logic              done,
    output logic [VA_W-1:0]   done_paddr,
    output logic [2:0]        done_prot,
    output logic [2:0]        done_fault
);
    localparam int unsigned IMPL_VA_BITS = PAGE_BITS + LEVELS * IDX_BITS;
    localparam int unsigned VPN_W        = LEVELS * IDX_BITS;
    localparam int unsigned LVL_W        = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned NMODE        = 1 << MODE_W;

    typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} state_e;

    state_e                  state;
    logic [LVL_W-1:0]        level;
    logic [IMPL_VA_BITS-1:0] va_q;
    logic [2:0]              need_q;
    logic [MODE_W-1:0]       mode_q;
    logic [VA_W-1:0]         base_q;
    logic [VA_W-1:0]         res_paddr;
    logic [2:0]              res_prot;
    fault_e                  res_fault;

    logic                    pre_resolved;
    fault_e                  pre_fault;
    logic [VA_W-1:0]         pre_paddr;
    logic [2:0]              pre_prot;
    fault_e                  leaf_fault;
    logic [2:0]              leaf_prot;
    logic [VA_W-1:0]         frame;
    logic                    last_level;
    logic                    pte_unused;

    ptw_precheck #(
        .VA_W(VA_W), .IMPL_VA_BITS(IMPL_VA_BITS), .MODE_W(MODE_W)
    ) u_pre (
        .vaddr(req_vaddr), .mode(req_mode), .bypass(req_phys),
        .resolved(pre_resolved), .fault(pre_fault),
        .paddr(pre_paddr), .prot(pre_prot)
    );

    ptw_index_gen #(
        .PA_W(VA_W), .IDX_BITS(IDX_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_idx (
        .vpn(va_q[PAGE_BITS +: VPN_W]), .level(level),
        .base(base_q), .addr(mem_req_addr)
    );

    ptw_leaf_perm #(
        .MODE_W(MODE_W)
    ) u_leaf (
        .valid(mem_rsp_data[PTE_VALID]),
        .fo_bits(mem_rsp_data[PTE_FO_LSB +: 3]),
        .rd_en(mem_rsp_data[PTE_RD_LSB +: NMODE]),
        .wr_en(mem_rsp_data[PTE_WR_LSB +: NMODE]),
        .mode(mode_q), .need(need_q),
        .fault(leaf_fault), .prot(leaf_prot)
    );

    // Entry bits that play no part in translation.
    assign pte_unused = ^{mem_rsp_data[VA_W-PFN_W-1:PTE_WR_LSB+NMODE], mem_rsp_data[PTE_RD_LSB-1:PTE_FO_LSB+3]};

    // Next table base or page frame from the entry's upper field.
    assign frame      = {{(VA_W-PFN_W){1'b0}}, mem_rsp_data[VA_W-1 -: PFN_W]} << PAGE_BITS;
    assign last_level = (level == LVL_W'(LEVELS-1));

    // Sequence accept, per-level reads and the result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            level     <= '0;
            va_q      <= '0;
            need_q    <= '0;
            mode_q    <= '0;
            base_q    <= '0;
            res_paddr <= '0;
            res_prot  <= '0;
            res_fault <= FLT_NONE;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr[IMPL_VA_BITS-1:0];
                        need_q <= req_need;
                        mode_q <= req_mode;
                        if (pre_resolved) begin
                            res_paddr <= pre_paddr;
                            res_prot  <= pre_prot;
                            res_fault <= pre_fault;
                            state     <= S_DONE;
                        end else begin
                            base_q <= ptbr;
                            level  <= '0;
                            state  <= S_WALK;
                        end
                    end
                end
                S_WALK: begin
                    if (mem_rsp_valid) begin
                        if (last_level) begin
                            res_fault <= leaf_fault;
                            res_prot  <= leaf_prot;
                            res_paddr <= (leaf_fault == FLT_NONE) ?
                                (frame | {{(VA_W-PAGE_BITS){1'b0}}, va_q[PAGE_BITS-1:0]}) : '0;
                            state     <= S_DONE;
                        end else if (!mem_rsp_data[PTE_VALID]) begin
                            res_fault <= FLT_NOTVALID;
                            res_prot  <= '0;
                            res_paddr <= '0;
                            state     <= S_DONE;
                        end else if (!mem_rsp_data[PTE_RD_LSB]) begin
                            res_fault <= FLT_ACCESS;
                            res_prot  <= '0;
                            res_paddr <= '0;
                            state     <= S_DONE;
                        end else begin
                            base_q <= frame;
                            level  <= level + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    assign busy          = (state != S_IDLE);
    assign done          = (state == S_DONE);
    assign mem_req_valid = (state == S_WALK);
    assign done_paddr    = res_paddr;
    assign done_prot     = res_prot;
    assign done_fault    = res_fault;

endmodule

// File: rtl/ptw_checker.sv
// Cycle-level properties of the walker, attached by bind.
// It tracks bypass requests itself, from the accept cycle to the done pulse.
module ptw_checker #(
    parameter int unsigned VA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_phys,
    input logic            mem_req_valid,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            busy,
    input logic            done,
    input logic [VA_W-1:0] done_paddr,
    input logic [2:0]      done_prot,
    input logic [2:0]      done_fault
);
    logic            byp_pend;
    logic [VA_W-1:0] va_cap;

    // Remember whether the accepted request was a bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_pend <= 1'b0;
            va_cap   <= '0;
        end else if (req_valid && !busy) begin
            byp_pend <= req_phys;
            va_cap   <= req_vaddr;
        end else if (done) begin
            byp_pend <= 1'b0;
        end
    end

    p_bypass_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byp_pend |-> !mem_req_valid);
    p_bypass_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byp_pend) |-> (done_paddr == va_cap && done_prot == 3'b111 && done_fault == 3'd0));
    p_fault_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault != 3'd0) |-> (done_prot == 3'b000 && done_paddr == '0));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
    p_req_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
    p_fault_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_fault <= 3'd5));

endmodule

bind pt_walker ptw_checker #(.VA_W(VA_W)) u_ptw_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_phys(req_phys), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .busy(busy), .done(done),
    .done_paddr(done_paddr), .done_prot(done_prot), .done_fault(done_fault)
);

// File: tb/tb_pt_walker.sv
// Scoreboard bench: the issue task queues expectations, the negedge monitor compares.
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [2:0]  req_need = '0;
    logic [1:0]  req_mode = '0;
    logic        req_phys = 1'b0;
    logic [63:0] ptbr = 64'h0010_0000;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        busy, done;
    logic [63:0] done_paddr;
    logic [2:0]  done_prot, done_fault;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_need(req_need), .req_mode(req_mode), .req_phys(req_phys), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .done_paddr(done_paddr),
        .done_prot(done_prot), .done_fault(done_fault)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [63:0] paddr;
        logic [2:0]  prot;
        logic [2:0]  fault;
        int          reads;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] mem [logic [63:0]];
    int          checks = 0;
    int          fails = 0;
    int          walk_reads = 0;
    int          lat_cnt = 0;
    int          extra_done = 0;
    int          stable_err = 0;
    logic [63:0] held_addr = '0;
    localparam int MEM_LAT = 2;

    localparam int F_V = 1, F_FOR = 2, F_FOW = 4, F_FOE = 8;
    localparam int F_RE0 = 'h100, F_RE1 = 'h200, F_WE0 = 'h1000, F_WE2 = 'h4000;
    localparam logic [63:0] L2_BASE = 64'h200 << 13;
    localparam logic [63:0] L3_BASE = 64'h300 << 13;

    function automatic logic [63:0] mkva(int l1, int l2, int l3, int off);
        return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
    endfunction

    function automatic logic [63:0] mkpte(int pfn, int fl);
        return (64'(pfn) << 32) | 64'(fl);
    endfunction

    function automatic logic [63:0] leaf_pa(int l3, int off);
        return (64'(32'h1000 + l3) << 13) | 64'(off);
    endfunction

    // Monitor and memory model, both away from the active edge.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                extra_done++;
                fails++;
                $display("FAIL R11 unexpected done: got paddr=%h fault=%0d, expected no result", done_paddr, done_fault);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (done_paddr !== e.paddr || done_prot !== e.prot || done_fault !== e.fault || walk_reads != e.reads) begin
                    fails++;
                    $display("FAIL %s: got paddr=%h prot=%b fault=%0d reads=%0d, expected paddr=%h prot=%b fault=%0d reads=%0d",
                             e.tag, done_paddr, done_prot, done_fault, walk_reads, e.paddr, e.prot, e.fault, e.reads);
                end
            end
            walk_reads = 0;
        end
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
            lat_cnt = 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            lat_cnt = 0;
        end else if (mem_req_valid) begin
            if (lat_cnt == 0) held_addr = mem_req_addr;
            else if (mem_req_addr !== held_addr) stable_err++;
            if (lat_cnt == MEM_LAT) begin
                mem_rsp_data  = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                mem_rsp_valid = 1'b1;
                walk_reads++;
                lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic issue(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                         input logic phys, input logic [63:0] ep, input logic [2:0] eprot,
                         input logic [2:0] ef, input int erd, input string tag);
        exp_t e;
        e.paddr = ep; e.prot = eprot; e.fault = ef; e.reads = erd; e.tag = tag;
        @(negedge clk);
        while (busy) @(negedge clk);
        sb_q.push_back(e);
        req_vaddr = va; req_need = need; req_mode = mode; req_phys = phys; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no completion, expected test end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        mem[ptbr + 3*8]       = mkpte('h200, F_V | F_RE0);
        mem[ptbr + 6*8]       = mkpte('h210, F_V);
        mem[L2_BASE + 5*8]    = mkpte('h300, F_V | F_RE0);
        mem[L2_BASE + 10*8]   = mkpte('h310, F_V);
        mem[L3_BASE + 7*8]    = mkpte('h1007, F_V | F_RE0 | F_WE0);
        mem[L3_BASE + 9*8]    = mkpte('h1009, F_V | F_RE1);
        mem[L3_BASE + 10*8]   = mkpte('h100A, F_V | F_RE0 | F_WE0 | F_FOW);
        mem[L3_BASE + 11*8]   = mkpte('h100B, F_V | F_RE0 | F_WE0 | F_FOR | F_FOW | F_FOE);
        mem[L3_BASE + 12*8]   = mkpte('h100C, F_V | F_WE2);

        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || mem_req_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: got busy=%b done=%b memreq=%b, expected 0 0 0", busy, done, mem_req_valid);
        end
        rst_n = 1'b1;

        issue(64'hFFFF_8000_1234_5678, 3'b001, 2'd1, 1'b1, 64'hFFFF_8000_1234_5678, 3'b111, 3'd0, 0, "R1 bypass");
        issue(64'h0000_1000_0000_0000, 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd1, 0, "R2 noncanonical");
        issue(64'hFFFF_F800_0000_2000, 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd2, 1, "R2 canonical negative walked");
        issue(64'hFFFF_FD12_3456_789A, 3'b010, 2'd0, 1'b0, 64'h0000_0812_3456_789A, 3'b111, 3'd0, 0, "R3 superpage kernel");
        issue(64'hFFFF_FD12_3456_789A, 3'b001, 2'd1, 1'b0, 64'h0, 3'b000, 3'd1, 0, "R4 superpage user");
        issue(mkva(3, 5, 7, 'h123), 3'b001, 2'd0, 1'b0, leaf_pa(7, 'h123), 3'b111, 3'd0, 3, "R5 R10 full walk");
        issue(mkva(4, 0, 0, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd2, 1, "R6 level1 invalid");
        issue(mkva(6, 0, 0, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd1, 1, "R7 level1 no kernel read");
        issue(mkva(3, 9, 0, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd2, 2, "R6 level2 invalid");
        issue(mkva(3, 10, 0, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd1, 2, "R7 level2 no kernel read");
        issue(mkva(3, 5, 8, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd2, 3, "R6 level3 invalid");
        issue(mkva(3, 5, 9, 'h10), 3'b010, 2'd1, 1'b0, 64'h0, 3'b000, 3'd1, 3, "R8 mode1 write denied");
        issue(mkva(3, 5, 9, 'h10), 3'b100, 2'd1, 1'b0, leaf_pa(9, 'h10), 3'b101, 3'd0, 3, "R8 mode1 exec granted");
        issue(mkva(3, 5, 9, 'h10), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd1, 3, "R8 mode0 read denied");
        issue(mkva(3, 5, 12, 'h1FFF), 3'b010, 2'd2, 1'b0, leaf_pa(12, 'h1FFF), 3'b010, 3'd0, 3, "R8 mode2 write only");
        issue(mkva(3, 5, 10, 0), 3'b010, 2'd0, 1'b0, 64'h0, 3'b000, 3'd4, 3, "R9 fault on write");
        issue(mkva(3, 5, 10, 4), 3'b001, 2'd0, 1'b0, leaf_pa(10, 4), 3'b101, 3'd0, 3, "R9 R10 read survives mask");
        issue(mkva(3, 5, 11, 0), 3'b111, 2'd0, 1'b0, 64'h0, 3'b000, 3'd5, 3, "R9 execute priority");
        issue(mkva(3, 5, 11, 0), 3'b011, 2'd0, 1'b0, 64'h0, 3'b000, 3'd4, 3, "R9 write over read");
        issue(mkva(3, 5, 11, 0), 3'b001, 2'd0, 1'b0, 64'h0, 3'b000, 3'd3, 3, "R9 fault on read");
        issue(mkva(3, 5, 11, 8), 3'b000, 2'd0, 1'b0, leaf_pa(11, 8), 3'b000, 3'd0, 3, "R10 empty need succeeds");

        // R11: requests presented during a walk are dropped.
        begin
            exp_t e;
            e.paddr = leaf_pa(7, 'h40); e.prot = 3'b111; e.fault = 3'd0; e.reads = 3; e.tag = "R11 walk with busy request";
            @(negedge clk);
            sb_q.push_back(e);
            req_vaddr = mkva(3, 5, 7, 'h40); req_need = 3'b001; req_mode = 2'd0; req_phys = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            req_vaddr = 64'h0000_0000_0ABC_0000; req_phys = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0; req_phys = 1'b0;
            while (sb_q.size() != 0) @(negedge clk);
            repeat (10) @(negedge clk);
            checks++;
            if (extra_done != 0) begin
                fails++;
                $display("FAIL R11 busy request: got %0d extra results, expected 0", extra_done);
            end
        end

        checks++;
        if (stable_err != 0) begin
            fails++;
            $display("FAIL R12 request hold: got %0d address changes, expected 0", stable_err);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule